// File: doc/BRIEF.md
# Restart-Mode Pulse Width Timer

This block times the intervals between edges on one external input. A 16-bit up-counter advances on a count-enable strobe. When a qualified active edge arrives, the counter value is stored in a period capture register. In the same cycle the counter is reloaded with zero, so the stored value is already the edge-to-edge width and no subtraction is needed afterwards. A second capture register takes the counter value on the edge opposite to the selected one. Software can read from it how long the input stayed at its active level.

The input first passes through a two-flop synchronizer. It then goes through a sampled noise filter, which accepts a new level only after two consecutive sample strobes have seen it. The sample strobe rate can be set to one of four values. Each accepted active edge produces a one-cycle interrupt pulse. A sticky flag records a counter wrap that happened before any edge restarted the count.

Top module: `pulse_restart_timer`

## Requirements
- R1: On an accepted active edge, `period_cap` takes the counter value held just before that edge, and `count_val` reads 0 in the same cycle. With `tick_en` high on every cycle and active edges N cycles apart, `period_cap` reads N-1.
- R2: `count_val` goes up by one on every cycle in which `tick_en` is high and no active edge restarts it, and wraps from 0xFFFF to 0x0000. At any other time it holds its value.
- R3: The filter accepts a new input level only when two consecutive sample strobes both see it. A level that lasts for just one strobe produces no edge, no capture and no interrupt.
- R4: `samp_rate` sets the sample strobe period from a free-running divider: 00 gives every clock, 01 every 4 clocks, 10 every 16 clocks and 11 every 64 clocks. With 11, a level shorter than 64 clocks is never accepted.
- R5: With `edge_mode` 01 (rising active), an accepted falling edge loads `level_cap` with the counter value. With 00 (falling active), an accepted rising edge does so.
- R6: With `edge_mode` 11, both edges are active and `level_cap` never changes.
- R7: `edge_irq` is high for exactly one cycle for each accepted active edge. That cycle is the one in which the new `period_cap` value first appears.
- R8: `ovf_flag` is set when a tick carries the counter from 0xFFFF to 0 in a cycle with no active edge. It stays set until `ovf_clr` is high, and a set in the same cycle as a clear wins.
- R9: With `edge_mode` 10, no edge is active. `edge_irq` stays low and neither capture register changes.
- R10: While reset is asserted all outputs are 0. For three clocks after reset the filter copies the synchronized pin level without producing an edge, so a pin held high through reset causes no interrupt.
- R11: With `samp_rate` 00, `edge_irq` goes high on the fourth clock edge after the first edge that samples the new pin level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | 1 | Asynchronous external input being measured |
| tick_en | input | 1 | Count-enable strobe for the counter |
| edge_mode | input | 2 | 00 falling, 01 rising, 10 none, 11 both |
| samp_rate | input | 2 | Filter sample strobe select (1, 4, 16, 64 clocks) |
| ovf_clr | input | 1 | Clears the overflow flag |
| count_val | output | 16 | Current counter value |
| period_cap | output | 16 | Counter value captured on the active edge |
| level_cap | output | 16 | Counter value captured on the opposite edge |
| edge_irq | output | 1 | One-cycle pulse per accepted active edge |
| ovf_flag | output | 1 | Sticky counter-wrap flag |

## Verification
The overflow flag is the hardest condition to reach. It needs more than 65535 ticks in a row with no accepted active edge, so the bench holds the pin quiet and keeps `tick_en` high for about 65600 cycles before it checks and clears the flag. Filter rejection is the other delicate case. The bench drives pulses one strobe wide at the fastest rate, and pulses shorter than one strobe period at the slowest rate. A reference model follows each of these through the free-running divider phase on every cycle.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/pwt_in_filter.sv
// Two-flop synchronizer, sample divider and two-sample level filter.
module pwt_in_filter #(
  parameter int SAMP_SHIFT = 2,
  parameter int RSEL_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic [RSEL_W-1:0] samp_rate,
  output logic              rise_o,
  output logic              fall_o
);
  localparam int NSEL  = 1 << RSEL_W;
  localparam int DIV_W = SAMP_SHIFT * (NSEL - 1);

  logic             sync1_q, sync2_q;
  logic [DIV_W-1:0] div_q, div_d, samp_mask;
  logic             strobe;
  logic [1:0]       warm_q, warm_d;
  logic             lvl_q, lvl_d, pend_q, pend_d;
  logic             rise_q, rise_d, fall_q, fall_d;

  // sample strobe mask per rate select
  always_comb begin
    samp_mask = '0;
    for (int k = 0; k < NSEL; k++) begin
      if (samp_rate == RSEL_W'(k)) begin
        samp_mask = DIV_W'((64'd1 << (SAMP_SHIFT * k)) - 64'd1);
      end
    end
  end

  assign strobe = ((div_q & samp_mask) == '0);
  assign div_d  = div_q + DIV_W'(1);

  always_comb begin
    warm_d = warm_q;
    lvl_d  = lvl_q;
    pend_d = pend_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (warm_q != 2'b11) begin
      warm_d = warm_q + 2'd1;
      lvl_d  = sync2_q;
      pend_d = 1'b0;
    end else if (strobe) begin
      if (sync2_q == lvl_q) begin
        pend_d = 1'b0;
      end else if (pend_q) begin
        lvl_d  = sync2_q;
        pend_d = 1'b0;
        rise_d = sync2_q;
        fall_d = ~sync2_q;
      end else begin
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      div_q   <= '0;
      warm_q  <= 2'b00;
      lvl_q   <= 1'b0;
      pend_q  <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      div_q   <= div_d;
      warm_q  <= warm_d;
      lvl_q   <= lvl_d;
      pend_q  <= pend_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/pwt_edge_decode.sv
// Maps filtered edges to restart and opposite-edge capture requests.
module pwt_edge_decode (
  input  logic                   rise_i,
  input  logic                   fall_i,
  input  pwt_pkg::edge_mode_e    mode_i,
  output logic                   restart_o,
  output logic                   snap_o
);
  always_comb begin
    restart_o = 1'b0;
    snap_o    = 1'b0;
    case (mode_i)
      pwt_pkg::EDGE_RISE: begin
        restart_o = rise_i;
        snap_o    = fall_i;
      end
      pwt_pkg::EDGE_FALL: begin
        restart_o = fall_i;
        snap_o    = rise_i;
      end
      pwt_pkg::EDGE_BOTH: begin
        restart_o = rise_i | fall_i;
        snap_o    = 1'b0;
      end
      default: begin
        restart_o = 1'b0;
        snap_o    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pwt_count_core.sv
// Counter with capture-then-clear, opposite-edge capture and wrap flag.
module pwt_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             restart,
  input  logic             snap_lvl,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] level_o,
  output logic             irq_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d, lev_q, lev_d;
  logic             irq_q, irq_d, ovf_q, ovf_d, wrap;

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    lev_d = lev_q;
    irq_d = restart;
    wrap  = 1'b0;
    if (restart) begin
      per_d = cnt_q;
      cnt_d = '0;
    end else if (tick_en) begin
      cnt_d = cnt_q + CNT_W'(1);
      wrap  = (cnt_q == CNT_MAX);
    end
    if (snap_lvl) begin
      lev_d = cnt_q;
    end
    if (wrap) begin
      ovf_d = 1'b1;
    end else if (ovf_clr) begin
      ovf_d = 1'b0;
    end else begin
      ovf_d = ovf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      lev_q <= '0;
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      lev_q <= lev_d;
      irq_q <= irq_d;
      ovf_q <= ovf_d;
    end
  end

  assign count_o  = cnt_q;
  assign period_o = per_q;
  assign level_o  = lev_q;
  assign irq_o    = irq_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/pulse_restart_timer.sv
module pulse_restart_timer #(
  parameter int CNT_W      = 16,
  parameter int SAMP_SHIFT = 2,
  parameter int RSEL_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic              tick_en,
  input  logic [1:0]        edge_mode,
  input  logic [RSEL_W-1:0] samp_rate,
  input  logic              ovf_clr,
  output logic [CNT_W-1:0]  count_val,
  output logic [CNT_W-1:0]  period_cap,
  output logic [CNT_W-1:0]  level_cap,
  output logic              edge_irq,
  output logic              ovf_flag
);
  logic [1:0] rs_q;
  logic       core_rst_n;
  logic       rise, fall, restart, snap;

  // reset release aligned to clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign core_rst_n = rs_q[1];

  pwt_in_filter #(
    .SAMP_SHIFT (SAMP_SHIFT),
    .RSEL_W     (RSEL_W)
  ) u_filt (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .pin_in    (pin_in),
    .samp_rate (samp_rate),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  pwt_edge_decode u_dec (
    .rise_i    (rise),
    .fall_i    (fall),
    .mode_i    (pwt_pkg::edge_mode_e'(edge_mode)),
    .restart_o (restart),
    .snap_o    (snap)
  );

  pwt_count_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .tick_en  (tick_en),
    .restart  (restart),
    .snap_lvl (snap),
    .ovf_clr  (ovf_clr),
    .count_o  (count_val),
    .period_o (period_cap),
    .level_o  (level_cap),
    .irq_o    (edge_irq),
    .ovf_o    (ovf_flag)
  );
endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       edge_mode,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] count_val,
  input logic [CNT_W-1:0] period_cap,
  input logic [CNT_W-1:0] level_cap,
  input logic             edge_irq,
  input logic             ovf_flag
);
  // R1
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_irq |-> (count_val == '0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_val != $past(count_val)) |->
      ((count_val == $past(count_val) + CNT_W'(1)) || (count_val == '0)));

  // R6
  both_no_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode == 2'b11) |=> $stable(level_cap));

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_irq |=> !edge_irq);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R8
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(count_val) == {CNT_W{1'b1}}));

  // R9
  none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode == 2'b10) |=> (!edge_irq && $stable(period_cap)));
endmodule

bind pulse_restart_timer pwt_checker #(.CNT_W(CNT_W)) u_pwt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .edge_mode  (edge_mode),
  .ovf_clr    (ovf_clr),
  .count_val  (count_val),
  .period_cap (period_cap),
  .level_cap  (level_cap),
  .edge_irq   (edge_irq),
  .ovf_flag   (ovf_flag)
);

// File: tb/test_pulse_restart_timer.sv
module test_pulse_restart_timer;
  logic        clk;
  logic        rst_n, pin_in, tick_en, ovf_clr;
  logic [1:0]  edge_mode, samp_rate;
  logic [15:0] count_val, period_cap, level_cap;
  logic        edge_irq, ovf_flag;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  int tick_div = 1;
  int phase = 0;
  bit cmp_on = 0;

  pulse_restart_timer i_pulse_restart_timer (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tick_en(tick_en),
    .edge_mode(edge_mode), .samp_rate(samp_rate), .ovf_clr(ovf_clr),
    .count_val(count_val), .period_cap(period_cap), .level_cap(level_cap),
    .edge_irq(edge_irq), .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, updated on every rising edge
  int m_rc, m_s1, m_s2, m_div, m_warm, m_lvl, m_pend, m_rp, m_fp;
  int m_cnt, m_per, m_lev, m_irq, m_ovf;

  always @(posedge clk) begin : model
    int strobe, act, opp, n_lvl, n_pend, n_rp, n_fp, wrapped;
    if (!rst_n || m_rc < 2) begin
      m_rc = rst_n ? m_rc + 1 : 0;
      m_s1 = 0; m_s2 = 0; m_div = 0; m_warm = 0; m_lvl = 0; m_pend = 0;
      m_rp = 0; m_fp = 0; m_cnt = 0; m_per = 0; m_lev = 0; m_irq = 0; m_ovf = 0;
    end else begin
      strobe = ((m_div & ((1 << (2 * samp_rate)) - 1)) == 0);
      act = 0; opp = 0;
      if (edge_mode == 2'b01) begin act = m_rp; opp = m_fp; end
      if (edge_mode == 2'b00) begin act = m_fp; opp = m_rp; end
      if (edge_mode == 2'b11) act = m_rp | m_fp;
      n_lvl = m_lvl; n_pend = m_pend; n_rp = 0; n_fp = 0;
      if (m_warm < 3) begin
        n_lvl = m_s2; n_pend = 0; m_warm = m_warm + 1;
      end else if (strobe != 0) begin
        if (m_s2 == m_lvl) n_pend = 0;
        else if (m_pend != 0) begin
          n_lvl = m_s2; n_pend = 0; n_rp = m_s2; n_fp = 1 - m_s2;
        end else n_pend = 1;
      end
      wrapped = 0;
      if (opp != 0) m_lev = m_cnt;
      if (act != 0) begin
        m_per = m_cnt; m_cnt = 0;
      end else if (tick_en) begin
        if (m_cnt == 65535) wrapped = 1;
        m_cnt = (m_cnt + 1) % 65536;
      end
      if (wrapped != 0) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      m_irq = act;
      m_lvl = n_lvl; m_pend = n_pend; m_rp = n_rp; m_fp = n_fp;
      m_s2 = m_s1; m_s1 = pin_in;
      m_div = (m_div + 1) % 64;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1 period_cap", period_cap, m_per);
      chk("R2 count_val", count_val, m_cnt);
      chk("R5 level_cap", level_cap, m_lev);
      chk("R7 edge_irq", edge_irq, m_irq);
      chk("R8 ovf_flag", ovf_flag, m_ovf);
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (edge_irq) irq_cnt++;
      phase++;
      tick_en = (tick_div <= 1) ? 1'b1 : ((phase % tick_div) == 0);
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    pin_in = 1'b1;
    run(hi);
    pin_in = 1'b0;
    run(lo);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    int lat, lv0, p0;
    rst_n = 1'b0; pin_in = 1'b1; tick_en = 1'b1; ovf_clr = 1'b0;
    edge_mode = 2'b01; samp_rate = 2'b00;
    run(4);
    // R10 reset state
    chk("R10 reset count", count_val, 0);
    chk("R10 reset period", period_cap, 0);
    chk("R10 reset level", level_cap, 0);
    chk("R10 reset irq", edge_irq, 0);
    chk("R10 reset ovf", ovf_flag, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    irq_cnt = 0;
    run(15);
    chk("R10 no edge from pin high at reset", irq_cnt, 0);

    // R11 latency, rising active
    pin_in = 1'b0;
    run(12);
    pin_in = 1'b1;
    lat = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (edge_irq && lat == 0) begin
        lat = i;
        chk("R1 count zero at irq", count_val, 0);
      end
    end
    chk("R11 latency", lat, 5);
    run(10);
    pin_in = 1'b0;
    run(20);

    // R1 / R5 rising active, period 20, high 8
    repeat (3) pulse(8, 12);
    chk("R1 period rising", period_cap, 19);
    chk("R5 level rising", level_cap, 7);

    // R5 falling active, low 12
    edge_mode = 2'b00;
    repeat (3) pulse(8, 12);
    chk("R1 period falling", period_cap, 19);
    chk("R5 level falling", level_cap, 11);

    // R6 both edges
    edge_mode = 2'b11;
    lv0 = level_cap;
    repeat (2) pulse(8, 12);
    chk("R6 level unchanged", level_cap, lv0);
    chk("R6 period last half", period_cap, 7);

    // R9 reserved mode
    edge_mode = 2'b10;
    p0 = period_cap;
    lv0 = level_cap;
    irq_cnt = 0;
    repeat (2) pulse(8, 12);
    chk("R9 no irq", irq_cnt, 0);
    chk("R9 period unchanged", period_cap, p0);
    chk("R9 level unchanged", level_cap, lv0);

    // R3 glitch rejection and two-sample acceptance
    edge_mode = 2'b01;
    run(20);
    irq_cnt = 0;
    pulse(1, 20);
    chk("R3 one-sample glitch", irq_cnt, 0);
    pulse(2, 20);
    chk("R3 two-sample accept", irq_cnt, 1);

    // R4 slowest sampling
    samp_rate = 2'b11;
    run(130);
    irq_cnt = 0;
    pulse(40, 200);
    chk("R4 short level at rate 64", irq_cnt, 0);
    pulse(200, 200);
    chk("R4 long level at rate 64", irq_cnt, 1);
    samp_rate = 2'b01;
    repeat (4) pulse(10, 14);
    samp_rate = 2'b10;
    repeat (3) pulse(40, 50);

    // R2 gated ticks
    samp_rate = 2'b00;
    tick_div = 3;
    repeat (4) pulse(15, 15);
    tick_div = 1;

    // R8 overflow
    ovf_clr = 1'b1;
    run(1);
    ovf_clr = 1'b0;
    run(1);
    chk("R8 flag clear before wrap", ovf_flag, 0);
    run(65600);
    chk("R8 flag set after wrap", ovf_flag, 1);
    run(5);
    chk("R8 flag sticky", ovf_flag, 1);
    ovf_clr = 1'b1;
    run(1);
    ovf_clr = 1'b0;
    run(1);
    chk("R8 flag cleared", ovf_flag, 0);

    run(5);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule